// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This block stands in for the page write path of a byte-wide EEPROM. A host issues byte-write strobes with an address and a data byte. The first accepted write latches the page, which is the address bits above the page offset. Later writes to the same page go into a page buffer, and each one restarts a load-window timer. When that window runs out with no new accepted write, the controller enters a programming phase of fixed length. In that phase it commits every loaded byte of the page into a behavioural memory array, and the bytes that were not loaded keep their old contents.

While a write sequence is active (loading or programming), the host can poll for completion. It reads the last byte it wrote and gets that byte back with bit 7 inverted. Once the controller is idle again, the same read returns the true byte. Reads of any other address return the array contents. Both timer lengths are parameters counted in clock cycles. A simulation can therefore use short windows in place of microsecond and millisecond values.

Top module: `eepg_ctrl`

## Requirements
- R1: After reset, `busy` and `page_err` are 0 and no write sequence is active.
- R2: A write strobe while idle is accepted. It latches `addr[ADDR_W-1:PAGE_BITS]` as the page and raises `busy` on the next cycle. The page stays fixed until the controller returns to idle.
- R3: Each accepted write during loading restarts the load window of `LOAD_CYC` cycles. An accepted write in the very cycle the window would expire also restarts it.
- R4: Programming begins `LOAD_CYC` cycles after the last accepted write and lasts exactly `PROG_CYC` cycles. If the last accepted write is sampled at clock edge k, `busy` falls at edge k+`LOAD_CYC`+`PROG_CYC`.
- R5: Every loaded offset of the page is in the array once `busy` falls. If one offset is written more than once, the last byte written to it is kept.
- R6: Offsets of the page that were not loaded keep their previous array contents.
- R7: During loading, a write whose upper address differs from the latched page is ignored. It does not restart the window, and `page_err` is high for the one cycle after it.
- R8: Writes during programming are ignored and do not raise `page_err`.
- R9: A read of the last accepted address while `busy` is high returns that byte with bit 7 inverted and bits 6..0 true. After `busy` falls, the same read returns the true byte. `rdata` holds the result from the cycle after `rd_en`.
- R10: A read of any other address returns the current array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for a read or a write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read result, valid the cycle after `rd_en` |
| busy | output | 1 | High during the load and programming phases |
| page_err | output | 1 | One-cycle flag for a rejected write to a different page |

## Verification
The two events that can fall in the same cycle are an accepted byte write and the expiry of the load window. The bench waits exactly `LOAD_CYC` cycles after one write and then sends the next, so that the strobe is sampled on the edge where the window would end. It then expects `busy` to stay high until `LOAD_CYC`+`PROG_CYC` cycles after the second write, and both bytes to be read back. In a second case, a rejected write to another page arrives while the window is running. The bench expects `busy` to fall on the schedule set by the earlier accepted write.

// File: rtl/eepg_pkg.sv
package eepg_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} wstate_t;
endpackage

// File: rtl/eepg_timer.sv
module eepg_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (start)             cnt <= CW'(CYC - 1);
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/eepg_page_buf.sv
module eepg_page_buf import eepg_pkg::*; #(
  parameter int PAGE_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [PAGE_BITS-1:0] widx,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 clr,
  input  logic [PAGE_BITS-1:0] ridx,
  output logic [BYTE_W-1:0]    rdat,
  output logic                 rvld
);
  localparam int PAGE = 1 << PAGE_BITS;
  logic [BYTE_W-1:0] data_q [PAGE];
  logic [PAGE-1:0]   vld_q;

  always_ff @(posedge clk) begin
    if (we) data_q[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= '0;
    else if (we)    vld_q[widx] <= 1'b1;
  end

  assign rdat = data_q[ridx];
  assign rvld = vld_q[ridx];
endmodule

// File: rtl/eepg_mem.sv
module eepg_mem import eepg_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= cells[raddr];
  end
endmodule

// File: rtl/eepg_ctrl.sv
module eepg_ctrl import eepg_pkg::*; #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_BITS = 7,
  parameter int LOAD_CYC  = 300,
  parameter int PROG_CYC  = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy,
  output logic              page_err
);
  localparam int UP_W = ADDR_W - PAGE_BITS;

  wstate_t            st;
  logic [UP_W-1:0]    page_q;
  logic [ADDR_W-1:0]  last_addr;
  logic [BYTE_W-1:0]  last_data;
  logic [PAGE_BITS:0] cidx;
  logic               poll_q;
  logic [BYTE_W-1:0]  poll_val;
  logic               load_exp, prog_exp;
  logic [BYTE_W-1:0]  buf_dat, mem_q;
  logic               buf_vld, mem_we;

  logic up_hit, accept, mismatch, go_prog;
  assign up_hit   = (addr[ADDR_W-1:PAGE_BITS] == page_q);
  assign accept   = wr_en && ((st == S_IDLE) || (st == S_LOAD && up_hit));
  assign mismatch = wr_en && (st == S_LOAD) && !up_hit;
  assign go_prog  = (st == S_LOAD) && !accept && load_exp;

  eepg_timer #(.CYC(LOAD_CYC)) u_load_tmr (
    .clk(clk), .rst(rst), .start(accept), .run(st == S_LOAD), .expired(load_exp));

  eepg_timer #(.CYC(PROG_CYC)) u_prog_tmr (
    .clk(clk), .rst(rst), .start(go_prog), .run(st == S_PROG), .expired(prog_exp));

  eepg_page_buf #(.PAGE_BITS(PAGE_BITS)) u_buf (
    .clk(clk), .rst(rst), .we(accept), .widx(addr[PAGE_BITS-1:0]), .wdata(wdata),
    .clr(st == S_PROG && prog_exp), .ridx(cidx[PAGE_BITS-1:0]),
    .rdat(buf_dat), .rvld(buf_vld));

  assign mem_we = (st == S_PROG) && !cidx[PAGE_BITS] && buf_vld;

  eepg_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr({page_q, cidx[PAGE_BITS-1:0]}), .wdata(buf_dat),
    .re(rd_en), .raddr(addr), .q(mem_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      page_q    <= '0;
      page_err  <= 1'b0;
      cidx      <= '0;
      last_addr <= '0;
      last_data <= '0;
      poll_q    <= 1'b0;
      poll_val  <= '0;
    end else begin
      page_err <= mismatch;
      unique case (st)
        S_IDLE: if (accept) begin
          st     <= S_LOAD;
          page_q <= addr[ADDR_W-1:PAGE_BITS];
        end
        S_LOAD: if (go_prog) st <= S_PROG;
        S_PROG: if (prog_exp) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (st != S_PROG)         cidx <= '0;
      else if (!cidx[PAGE_BITS]) cidx <= cidx + 1'b1;
      if (accept) begin
        last_addr <= addr;
        last_data <= wdata;
      end
      if (rd_en) begin
        poll_q   <= (st != S_IDLE) && (addr == last_addr);
        poll_val <= {~last_data[7], last_data[6:0]};
      end
    end
  end

  assign busy  = (st != S_IDLE);
  assign rdata = poll_q ? poll_val : mem_q;

  AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && wr_en) |=> busy); // R2
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(page_q)); // R2
  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOAD && accept) |=> (st == S_LOAD)); // R3
  AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st == S_PROG && $past(st == S_LOAD)) |-> !$past(accept)); // R4
  AST_ERR_BUSY: assert property (@(posedge clk) disable iff (rst)
    page_err |-> busy); // R7
  AST_PROG_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (st == S_PROG && wr_en) |=> !page_err); // R8
endmodule

// File: tb/eepg_ctrl_tb.sv
module eepg_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PB = 3;
  localparam int L  = 6;
  localparam int P  = 12;
  localparam int NV = 8;
  // {addr, data}: page 3 (base 24), offset 2 written twice
  localparam logic [17:0] VEC [NV] = '{
    {10'd24, 8'hA1}, {10'd25, 8'hB2}, {10'd26, 8'hC3}, {10'd27, 8'hD4},
    {10'd26, 8'h5E}, {10'd28, 8'hE5}, {10'd29, 8'hF6}, {10'd31, 8'h87}};

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy, page_err;
  logic [7:0] model [0:(1<<AW)-1];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eepg_ctrl #(.ADDR_W(AW), .PAGE_BITS(PB), .LOAD_CYC(L), .PROG_CYC(P)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .page_err(page_err));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 0;
    wait_n(1);
    chk(8'(busy), 8'd0, "R1 busy after reset");
    chk(8'(page_err), 8'd0, "R1 page_err after reset");

    // table walk: burst into page 3
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][17:8], VEC[i][7:0]);
      model[VEC[i][17:8]] = VEC[i][7:0];
      if (i == 0) chk(8'(busy), 8'd1, "R2 busy after first write");
    end
    rd(10'd31);
    chk(rdata, 8'h07, "R9 poll of last byte during load");
    wait_n(L + P - 2);
    chk(8'(busy), 8'd1, "R4 busy one cycle before end");
    wait_n(1);
    chk(8'(busy), 8'd0, "R4 busy falls on schedule");
    for (int a = 24; a < 32; a++) begin
      if (a == 30) continue;
      rd(AW'(a));
      chk(rdata, model[a], "R5 committed byte");
    end
    rd(10'd31);
    chk(rdata, 8'h87, "R9 true data after programming");

    // partial page rewrite
    wr(10'd25, 8'hC2);
    model[25] = 8'hC2;
    rd(10'd25);
    chk(rdata, 8'h42, "R9 poll bit7 inverted");
    wait_n(L + P);
    rd(10'd24); chk(rdata, model[24], "R6 unloaded offset kept");
    rd(10'd26); chk(rdata, model[26], "R6 unloaded offset kept");
    rd(10'd25); chk(rdata, 8'hC2, "R5 rewritten offset");

    // setup pages for later checks
    wr(10'd49, 8'h3C); model[49] = 8'h3C; wait_n(L + P);
    wr(10'd16, 8'h11); wr(10'd17, 8'h22); model[16] = 8'h11; model[17] = 8'h22;
    wait_n(L + P);

    // R7: cross-page write rejected, timer not restarted
    wr(10'd40, 8'h5A); model[40] = 8'h5A;
    wr(10'd49, 8'hFF);
    chk(8'(page_err), 8'd1, "R7 page_err after cross-page write");
    wait_n(1);
    chk(8'(page_err), 8'd0, "R7 page_err is one cycle");
    wait_n(L + P - 3);
    chk(8'(busy), 8'd1, "R7 busy before original end");
    wait_n(1);
    chk(8'(busy), 8'd0, "R7 window not restarted");
    rd(10'd49); chk(rdata, 8'h3C, "R7 rejected byte not stored");
    rd(10'd40); chk(rdata, 8'h5A, "R7 accepted byte stored");

    // R8: write during programming ignored; R10 other read while busy
    wr(10'd16, 8'h99); model[16] = 8'h99;
    wait_n(L);
    wr(10'd17, 8'h77);
    chk(8'(page_err), 8'd0, "R8 no page_err during programming");
    rd(10'd49);
    chk(rdata, 8'h3C, "R10 other address read while busy");
    wait_n(P - 3);
    chk(8'(busy), 8'd1, "R8 busy before end");
    wait_n(1);
    chk(8'(busy), 8'd0, "R8 schedule unchanged");
    rd(10'd17); chk(rdata, 8'h22, "R8 ignored byte not stored");
    rd(10'd16); chk(rdata, 8'h99, "R5 loaded byte stored");

    // R3: write collides with window expiry
    wr(10'd44, 8'h81);
    wait_n(L - 1);
    wr(10'd45, 8'h92);
    wait_n(L + P - 1);
    chk(8'(busy), 8'd1, "R3 window restarted by colliding write");
    wait_n(1);
    chk(8'(busy), 8'd0, "R3 end after restarted window");
    rd(10'd44); chk(rdata, 8'h81, "R3 first byte stored");
    rd(10'd45); chk(rdata, 8'h92, "R3 colliding byte stored");

    // R1: reset in the middle of loading
    wr(10'd8, 8'h01);
    rst = 1; wait_n(1); rst = 0;
    chk(8'(busy), 8'd0, "R1 reset clears busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule